// File: doc/BRIEF.md
# Framed C-Channel Control and Status Register

This block terminates an 8-bit control/status byte carried in one fixed time slot of a framed serial stream. The bit clock arrives as a one-cycle enable, `bit_en`, in the system clock domain. The frame pulse marks bit 0 of every frame. The block shifts the slot in from `sin` and out on `sout`, most significant bit first. It keeps three registers: a control register, a diagnostic register, and a shared data register.

The control source is picked by `ps_sel`.

- **Processor mode (`ps_sel` = 1):**
  - A small microport writes the control and diagnostic registers.
  - The processor can override the outgoing byte for exactly one frame.
- **Serial mode (`ps_sel` = 0):**
  - The port is ignored.
  - The received slot byte reloads the control register every frame.

By default the outgoing slot carries the `mode_status` word. Bit 1 of the control register can hold the diagnostic register at zero until the 2-bit activation status reads 1,1.

Top module: `cch_ctl`

## Requirements
- R1: With `ps_sel`=0, microport writes to any address change no register. Control, data and diagnostic contents read back unchanged.
- R2: With `ps_sel`=0, the byte received in the slot is loaded into the control register when the slot's last bit arrives, in every frame.
- R3: With `ps_sel`=1, a write to address 0 goes to the control register when `up_wdata[0]`=0 and to the diagnostic register when `up_wdata[0]`=1. The control register then keeps its value across frames.
- R4: While control bit 1 is 1 and `act_st` is not 2'b11, the diagnostic register is held at zero, and writes to it have no effect. With `act_st`=2'b11, it accepts writes.
- R5: The outgoing slot carries the `mode_status` value sampled on the bit enable where `fp` is high, unless R6 applies.
- R6: With `ps_sel`=1, a write to address 1 during frame N makes that byte the outgoing slot of frame N+1 only. Frame N+2 reverts to `mode_status` unless it is written again.
- R7: A write to address 1 while `fp` is high is ignored. It changes neither the data register nor the next frame's outgoing byte.
- R8: The data register at address 1 is shared. It reads back the last received slot byte. A write replaces that byte, and the next reception replaces it again.
- R9: The slot occupies bits SLOT_IDX*8 to SLOT_IDX*8+7, counted from the bit sampled with `fp` high as bit 0, shifted MSB first. `sout` is 1 outside the slot.
- R10: After reset, all three registers read 0 and `sout` is 1. Read addresses: 0 control, 1 data, 2 diagnostic, 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| fp | input | 1 | Frame pulse; high on bit 0 of a frame |
| sin | input | 1 | Serial receive stream |
| sout | output | 1 | Serial transmit stream |
| ps_sel | input | 1 | 1 = processor control, 0 = serial control |
| act_st | input | 2 | Activation status; 2'b11 = active |
| mode_status | input | 8 | Default outgoing slot byte |
| up_wr | input | 1 | Microport write strobe |
| up_addr | input | 2 | Microport register address |
| up_wdata | input | 8 | Microport write data |
| up_rdata | output | 8 | Microport read data (combinational) |

## Verification
Register reads are combinational, so the bench reads one settled cycle after any write. The diagnostic hold acts on the clock after the control bit is set, so diagnostic checks wait until the end of the frame.

Each received byte is due in the shared and control registers one clock after the bit enable of the slot's last bit. The bench therefore reads them only after the frame ends.

Each `sout` bit is registered on the bit enable that carries that bit index. The bench samples it on the next falling edge.

The outgoing byte is chosen on the frame-pulse bit enable. The bench predicts it from the model state at that moment. As a result, override writes are scored one frame late, and an override is checked again when the frame after it reverts.

// File: rtl/cch_pkg.sv
package cch_pkg;
    localparam int BYTE_W  = 8;
    localparam int CLR_BIT = 1;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_DATA = 2'd1,
        ADR_DIAG = 2'd2,
        ADR_NONE = 2'd3
    } cch_addr_e;

    typedef struct packed {
        logic                wr;
        cch_addr_e           addr;
        logic [BYTE_W-1:0]   data;
    } port_wr_t;

    typedef struct packed {
        logic       frame_start;
        logic       slot_bit;
        logic       slot_last;
        logic [2:0] pos;
    } slot_tick_t;

    function automatic logic link_active(input logic [1:0] st);
        return st == 2'b11;
    endfunction
endpackage

// File: rtl/cch_slot_timer.sv
module cch_slot_timer
    import cch_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int SLOT_IDX   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       fp,
    output slot_tick_t tick
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LO   = CNT_W'(SLOT_IDX * BYTE_W);
    localparam logic [CNT_W-1:0] HI   = CNT_W'(SLOT_IDX * BYTE_W + BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0] bcnt;
    logic [CNT_W-1:0] cur;
    logic             in_slot;

    assign cur     = fp ? '0 : bcnt;
    assign in_slot = (cur >= LO) && (cur <= HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt <= '0;
        end else if (bit_en) begin
            bcnt <= (cur == LAST) ? '0 : cur + 1'b1;
        end
    end

    always_comb begin
        tick.frame_start = bit_en && fp;
        tick.slot_bit    = bit_en && in_slot;
        tick.slot_last   = bit_en && (cur == HI);
        tick.pos         = 3'(cur - LO);
    end

    // R9: the frame pulse bit is bit 0, so the next bit index is 1
    p_frame_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_en && fp) |=> (bcnt == CNT_W'(1)));
endmodule

// File: rtl/cch_serdes.sv
module cch_serdes
    import cch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  slot_tick_t        tick,
    input  logic              sin,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done,
    output logic              sout
);
    logic [BYTE_W-2:0] rx_sh;

    assign rx_byte = {rx_sh, sin};
    assign rx_done = tick.slot_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh <= '0;
            sout  <= 1'b1;
        end else if (bit_en) begin
            if (tick.slot_bit) begin
                rx_sh <= {rx_sh[BYTE_W-3:0], sin};
                sout  <= tx_byte[3'd7 - tick.pos];
            end else begin
                sout  <= 1'b1;
            end
        end
    end

    // R9: line idles high outside the slot
    p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !tick.slot_bit) |=> sout);
endmodule

// File: rtl/cch_regs.sv
module cch_regs
    import cch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fp,
    input  logic              ps_sel,
    input  logic [1:0]        act_st,
    input  logic [BYTE_W-1:0] mode_status,
    input  slot_tick_t        tick,
    input  port_wr_t          wreq,
    input  cch_addr_e         raddr,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_done,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] ctrl_q, diag_q, data_q;
    logic              pend_q;
    logic              hold_diag;

    assign hold_diag = ctrl_q[CLR_BIT] && !link_active(act_st);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            diag_q  <= '0;
            data_q  <= '0;
            pend_q  <= 1'b0;
            tx_byte <= '0;
        end else begin
            if (tick.frame_start) begin
                tx_byte <= (ps_sel && pend_q) ? data_q : mode_status;
                pend_q  <= 1'b0;
            end
            if (rx_done) begin
                data_q <= rx_byte;
                if (!ps_sel) ctrl_q <= rx_byte;
            end
            if (wreq.wr && ps_sel) begin
                unique case (wreq.addr)
                    ADR_CTRL: begin
                        if (wreq.data[0]) diag_q <= wreq.data;
                        else              ctrl_q <= wreq.data;
                    end
                    ADR_DATA: begin
                        if (!fp) begin
                            data_q <= wreq.data;
                            pend_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (hold_diag) diag_q <= '0;
        end
    end

    always_comb begin
        unique case (raddr)
            ADR_CTRL: rdata = ctrl_q;
            ADR_DATA: rdata = data_q;
            ADR_DIAG: rdata = diag_q;
            default:  rdata = '0;
        endcase
    end

    // R1: port writes in serial mode leave control and data alone
    p_serial_ignores_port_r1: assert property (@(posedge clk) disable iff (rst)
        (wreq.wr && !ps_sel && !rx_done) |=> ($stable(ctrl_q) && $stable(data_q)));
    // R2: serial mode reloads control from the received slot
    p_serial_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !ps_sel) |=> (ctrl_q == $past(rx_byte)));
    // R4: diagnostic held at zero until activation
    p_diag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CLR_BIT] && act_st != 2'b11) |=> (diag_q == '0));
    // R5: serial mode always sends the status word
    p_status_default_r5: assert property (@(posedge clk) disable iff (rst)
        (tick.frame_start && !ps_sel) |=> (tx_byte == $past(mode_status)));
    // R7: no override is armed by a write inside the frame pulse
    p_no_fp_override_r7: assert property (@(posedge clk) disable iff (rst)
        (wreq.wr && wreq.addr == ADR_DATA && fp && !pend_q) |=> !pend_q);
endmodule

// File: rtl/cch_ctl.sv
module cch_ctl
    import cch_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int SLOT_IDX   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       fp,
    input  logic       sin,
    output logic       sout,
    input  logic       ps_sel,
    input  logic [1:0] act_st,
    input  logic [7:0] mode_status,
    input  logic       up_wr,
    input  logic [1:0] up_addr,
    input  logic [7:0] up_wdata,
    output logic [7:0] up_rdata
);
    slot_tick_t        tick;
    port_wr_t          wreq;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic              rx_done;

    always_comb begin
        wreq.wr   = up_wr;
        wreq.addr = cch_addr_e'(up_addr);
        wreq.data = up_wdata;
    end

    cch_slot_timer #(.FRAME_BITS(FRAME_BITS), .SLOT_IDX(SLOT_IDX)) u_timer (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fp(fp), .tick(tick)
    );

    cch_serdes u_serdes (
        .clk(clk), .rst(rst), .bit_en(bit_en), .tick(tick), .sin(sin),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_done(rx_done), .sout(sout)
    );

    cch_regs u_regs (
        .clk(clk), .rst(rst), .fp(fp), .ps_sel(ps_sel), .act_st(act_st),
        .mode_status(mode_status), .tick(tick), .wreq(wreq),
        .raddr(cch_addr_e'(up_addr)), .rx_byte(rx_byte), .rx_done(rx_done),
        .tx_byte(tx_byte), .rdata(up_rdata)
    );
endmodule

// File: tb/tb_cch_ctl.sv
`timescale 1ns/1ps
module tb_cch_ctl;
    localparam int FB = 32;
    localparam int SI = 1;
    localparam int LO = SI * 8;
    localparam int HI = LO + 7;

    logic clk = 0, rst = 1, bit_en = 0, fp = 0, sin = 0;
    logic ps_sel = 1, up_wr = 0;
    logic [1:0] act_st = 0, up_addr = 0;
    logic [7:0] mode_status = 0, up_wdata = 0;
    logic sout;
    logic [7:0] up_rdata;

    int total = 0, bad = 0, cycles = 0;

    // bench model
    logic [7:0] m_ctrl = 0, m_diag = 0, m_data = 0, m_tx = 0;
    bit m_pend = 0;

    always #2 clk = ~clk;

    cch_ctl #(.FRAME_BITS(FB), .SLOT_IDX(SI)) dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fp(fp), .sin(sin), .sout(sout),
        .ps_sel(ps_sel), .act_st(act_st), .mode_status(mode_status),
        .up_wr(up_wr), .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] held(input logic [7:0] d);
        return (m_ctrl[1] && act_st != 2'b11) ? 8'h00 : d;
    endfunction

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        up_addr = a;
        #1;
        check(req, up_rdata, exp);
    endtask

    // one port write, strobe held for one clock; model applied per R1/R3/R4/R6/R7
    task automatic port_write(input logic [1:0] a, input logic [7:0] d);
        up_addr = a; up_wdata = d; up_wr = 1;
        @(negedge clk);
        up_wr = 0;
        if (ps_sel) begin
            if (a == 2'd0) begin
                if (d[0]) m_diag = d; else m_ctrl = d;
            end else if (a == 2'd1 && !fp) begin
                m_data = d; m_pend = 1;
            end
        end
        m_diag = held(m_diag);
    endtask

    task automatic run_frame(input logic [7:0] rxb, input bit w_en, input logic [1:0] w_a,
                             input logic [7:0] w_d, input bit fp_wr, input logic [7:0] fp_d);
        logic [7:0] cap;
        cap = 0;
        // R5/R6: outgoing byte chosen at frame start
        m_tx = (ps_sel && m_pend) ? m_data : mode_status;
        m_pend = 0;
        m_diag = held(m_diag);
        for (int b = 0; b < FB; b++) begin
            @(negedge clk);
            bit_en = 1; fp = (b == 0);
            sin = (b >= LO && b <= HI) ? rxb[7 - (b - LO)] : 1'($urandom);
            @(negedge clk);
            bit_en = 0;
            if (b >= LO && b <= HI) cap[7 - (b - LO)] = sout;
            if (b == 3) check("R9 idle high", {7'd0, sout}, 8'd1);
            if (b == HI) begin
                m_data = rxb;
                if (!ps_sel) m_ctrl = rxb;
                m_diag = held(m_diag);
            end
            @(negedge clk);
            if (b == 0 && fp_wr) port_write(2'd1, fp_d);
            else if (b == 20 && w_en) port_write(w_a, w_d);
            else @(negedge clk);
        end
        check("R5/R6/R9 slot byte", cap, m_tx);
        read_chk(2'd0, m_ctrl, "R1/R2/R3 control");
        read_chk(2'd2, m_diag, "R1/R3/R4 diag");
        read_chk(2'd1, m_data, "R1/R8 data");
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 0;
        // R10 reset state
        read_chk(2'd0, 8'h00, "R10 ctrl");
        read_chk(2'd1, 8'h00, "R10 data");
        read_chk(2'd2, 8'h00, "R10 diag");
        read_chk(2'd3, 8'h00, "R10 addr3");
        check("R10 sout", {7'd0, sout}, 8'd1);

        ps_sel = 1; mode_status = 8'h5A; act_st = 2'b00;
        run_frame(8'h11, 1, 2'd1, 8'h3C, 0, 0);   // R6: override armed
        run_frame(8'h22, 0, 0, 0, 0, 0);           // R6: 3C sent
        run_frame(8'h33, 0, 0, 0, 0, 0);           // R6: reverts to 5A
        run_frame(8'h44, 0, 0, 0, 1, 8'h77);       // R7: write during fp ignored
        run_frame(8'h55, 0, 0, 0, 0, 0);           // R7: no override follows
        run_frame(8'h66, 1, 2'd0, 8'h81, 0, 0);    // R3: bit0=1 -> diag
        run_frame(8'h77, 1, 2'd0, 8'h02, 0, 0);    // R4: clear bit held, not active
        run_frame(8'h88, 1, 2'd0, 8'hF3, 0, 0);    // R4: diag write blocked
        act_st = 2'b11;
        run_frame(8'h99, 1, 2'd0, 8'h55, 0, 0);    // R4: active -> diag accepts
        ps_sel = 0; act_st = 2'b01; mode_status = 8'hC3;
        run_frame(8'h02, 1, 2'd0, 8'h40, 0, 0);    // R1/R2: serial reload, write ignored
        run_frame(8'hA4, 1, 2'd1, 8'hEE, 0, 0);    // R1: override ignored in serial mode
        run_frame(8'h00, 0, 0, 0, 0, 0);           // R5: status sent

        for (int f = 0; f < 40; f++) begin
            ps_sel = 1'($urandom);
            act_st = 2'($urandom);
            mode_status = 8'($urandom);
            run_frame(8'($urandom), 1'($urandom), 2'($urandom), 8'($urandom),
                      ($urandom % 4) == 0, 8'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule